// File: doc/BRIEF.md
# Cache Controller March Sequencer

This block is a hardware engine that tests a data cache controller by driving the cache's processor-side request port. It carries out a two-pass march over every data element of the cache. It tells a companion bus monitor, before each access, whether that access is expected to reach main memory. Data mismatches are caught by the sequencer itself. A wrong hit or miss is caught by the monitor, which raises the abort input.

A run begins with a flush request, so that every line is invalid. The first pass writes a pattern to each element and expects a miss, then reads it back and expects a hit. The second pass reads each element and expects a miss. It then writes the complement and expects a hit; for this write, main memory is expected to be touched only under write-through. A final read expects a hit. Element addresses come from an external generator, which is driven by the word and block indices that this block outputs. The word index is the outer loop and the block index is the inner loop.

Top module: `cache_march_seq`

## Requirements
- R1: A start pulse in the idle or done state raises flush_req. flush_req stays high until flush_ack is seen. No cache request is issued before then.
- R2: Every cache access is preceded by exactly one arm_stb cycle, placed in the cycle directly before the access is first presented. arm_allow in that cycle is 1 when the access is expected to reach main memory.
- R3: Pass one, per element, has two accesses. The first writes `pattern` with arm_allow=1. The second reads with arm_allow=0, and the read data must equal `pattern`.
- R4: Pass two, per element, has three accesses. The first reads with arm_allow=1 and expects `pattern`. The second writes `~pattern`, with arm_allow=0 when wb_mode=1 (write-back) and 1 when wb_mode=0 (write-through). The third reads with arm_allow=0 and expects `~pattern`.
- R5: Each pass visits ND*NB elements. The block index elem_blk advances fastest and the word index elem_word is the outer loop. The request address is agen_addr for the current indices. One idle_stb cycle follows the last access of every element.
- R6: While req_valid is high and req_ready is low, req_valid, req_we, req_addr and req_wdata hold their values.
- R7: A read whose rsp_rdata differs from the expected value ends the run. In the next cycle done=1 and fail=1, and fail_word and fail_blk hold that element's indices. No further requests follow.
- R8: A run with no mismatch and no abort ends with done=1 and fail=0 after 2*ND*NB idle strobes and a single flush.
- R9: abort high while a run is in progress gives done=1 and fail=1 in the next cycle.
- R10: done and fail hold until the next accepted start, which clears fail. A start pulse during a run has no effect.
- R11: After reset, done, fail, req_valid, flush_req, arm_stb and idle_stb are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (idle or done state only) |
| abort | input | 1 | Stop the run and flag failure (monitor interrupt) |
| wb_mode | input | 1 | 1 = write-back cache, 0 = write-through |
| pattern | input | DW | Test pattern b |
| flush_req | output | 1 | Full cache flush request |
| flush_ack | input | 1 | Flush completed |
| elem_word | output | WW | Word index to the address generator |
| elem_blk | output | BW | Block index to the address generator |
| agen_addr | input | AW | Address for the current indices |
| req_valid | output | 1 | Cache request valid |
| req_ready | input | 1 | Cache accepts request |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | DW | Read data |
| arm_stb | output | 1 | Expectation strobe to the bus monitor |
| arm_allow | output | 1 | Expected memory access for the next request |
| idle_stb | output | 1 | Monitor to idle after an element |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky failure flag |
| fail_word | output | WW | Word index at failure |
| fail_blk | output | BW | Block index at failure |

## Verification
Some properties are checked on every cycle. Requests stay stable while stalled. An arm strobe always leads straight into a request. Strobes and requests never overlap. The flush request is held until it is acknowledged. Abort and mismatch land in the failed done state one cycle later, fail stays sticky, and the block index moves first. Other behaviour only the scenarios can show: the exact access order, the data and expectation of each access per write policy, the failing indices, and that a start pulse during a run is ignored.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FLUSH = 3'd1,
    ST_ARM   = 3'd2,
    ST_ISSUE = 3'd3,
    ST_WAIT  = 3'd4,
    ST_QUIET = 3'd5,
    ST_DONE  = 3'd6
  } cms_state_e;

  // One access of an element's march step
  typedef struct packed {
    logic we;      // write access
    logic inv;     // use complemented pattern
    logic allow;   // memory access expected on the bus
    logic last;    // final access of the element
  } cms_op_t;

endpackage

// File: rtl/cms_step.sv
module cms_step
  import cms_pkg::*;
(
  input  logic       pass2,
  input  logic [1:0] step,
  input  logic       wb_mode,
  output cms_op_t    op
);

  always_comb begin
    if (pass2) begin
      // read(miss) , write ~b (hit) , read(hit)
      op.we    = (step == 2'd1);
      op.allow = (step == 2'd0) || ((step == 2'd1) && !wb_mode);
      op.last  = (step == 2'd2);
      op.inv   = (step != 2'd0);
    end else begin
      // write b (miss) , read(hit)
      op.we    = (step == 2'd0);
      op.allow = (step == 2'd0);
      op.last  = (step == 2'd1);
      op.inv   = 1'b0;
    end
  end

endmodule

// File: rtl/cms_walk.sv
module cms_walk #(
  parameter int ND = 4,
  parameter int NB = 8,
  parameter int WW = 2,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [WW-1:0] word,
  output logic [BW-1:0] blk,
  output logic          last
);

  localparam logic [WW-1:0] WORD_MAX = WW'(ND - 1);
  localparam logic [BW-1:0] BLK_MAX  = BW'(NB - 1);

  logic [WW-1:0] word_q, word_d;
  logic [BW-1:0] blk_q, blk_d;

  always_comb begin
    word_d = word_q;
    blk_d  = blk_q;
    if (clr) begin
      word_d = '0;
      blk_d  = '0;
    end else if (adv) begin
      if (blk_q == BLK_MAX) begin
        blk_d  = '0;
        word_d = word_q + 1'b1;
      end else begin
        blk_d  = blk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      blk_q  <= '0;
    end else if (clr || adv) begin
      word_q <= word_d;
      blk_q  <= blk_d;
    end
  end

  assign word = word_q;
  assign blk  = blk_q;
  assign last = (word_q == WORD_MAX) && (blk_q == BLK_MAX);

  // R5: block index is the inner loop
  a_r5_inner_first: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && (blk_q != BLK_MAX)) |=>
      (word_q == $past(word_q)) && (blk_q == BW'($past(blk_q) + 1'b1)));

  // R5: word index only moves on a block wrap
  a_r5_outer_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && (blk_q == BLK_MAX)) |=> (blk_q == '0));

endmodule

// File: rtl/cache_march_seq.sv
module cache_march_seq
  import cms_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int ND = 4,
  parameter int NB = 8,
  localparam int WW = (ND > 1) ? $clog2(ND) : 1,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          wb_mode,
  input  logic [DW-1:0] pattern,
  output logic          flush_req,
  input  logic          flush_ack,
  output logic [WW-1:0] elem_word,
  output logic [BW-1:0] elem_blk,
  input  logic [AW-1:0] agen_addr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          arm_stb,
  output logic          arm_allow,
  output logic          idle_stb,
  output logic          done,
  output logic          fail,
  output logic [WW-1:0] fail_word,
  output logic [BW-1:0] fail_blk
);

  cms_state_e    state_q, state_d;
  logic          pass_q, pass_d;
  logic [1:0]    step_q, step_d;
  logic          fail_q, fail_d;
  logic [WW-1:0] fw_q, fw_d;
  logic [BW-1:0] fb_q, fb_d;
  logic          walk_clr, walk_adv, walk_last;
  logic          acc_done, busy;
  logic [DW-1:0] exp_data;
  cms_op_t       op;

  cms_step u_step (
    .pass2   (pass_q),
    .step    (step_q),
    .wb_mode (wb_mode),
    .op      (op)
  );

  cms_walk #(.ND(ND), .NB(NB), .WW(WW), .BW(BW)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (walk_clr),
    .adv   (walk_adv),
    .word  (elem_word),
    .blk   (elem_blk),
    .last  (walk_last)
  );

  assign exp_data = op.inv ? ~pattern : pattern;
  assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);

  // next-state process
  always_comb begin
    state_d  = state_q;
    pass_d   = pass_q;
    step_d   = step_q;
    fail_d   = fail_q;
    fw_d     = fw_q;
    fb_d     = fb_q;
    walk_clr = 1'b0;
    walk_adv = 1'b0;
    acc_done = 1'b0;
    if (busy && abort) begin
      fail_d  = 1'b1;
      fw_d    = elem_word;
      fb_d    = elem_blk;
      state_d = ST_DONE;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state_d  = ST_FLUSH;
            fail_d   = 1'b0;
            pass_d   = 1'b0;
            step_d   = 2'd0;
            walk_clr = 1'b1;
          end
        end
        ST_FLUSH: if (flush_ack) state_d = ST_ARM;
        ST_ARM:   state_d = ST_ISSUE;
        ST_ISSUE: begin
          if (req_ready) begin
            if (op.we) acc_done = 1'b1;
            else       state_d  = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_rdata != exp_data) begin
              fail_d  = 1'b1;
              fw_d    = elem_word;
              fb_d    = elem_blk;
              state_d = ST_DONE;
            end else begin
              acc_done = 1'b1;
            end
          end
        end
        ST_QUIET: begin
          step_d = 2'd0;
          if (walk_last) begin
            if (!pass_q) begin
              pass_d   = 1'b1;
              walk_clr = 1'b1;
              state_d  = ST_ARM;
            end else begin
              state_d  = ST_DONE;
            end
          end else begin
            walk_adv = 1'b1;
            state_d  = ST_ARM;
          end
        end
        default: state_d = ST_IDLE;
      endcase
      if (acc_done) begin
        if (op.last) begin
          state_d = ST_QUIET;
        end else begin
          step_d  = step_q + 2'd1;
          state_d = ST_ARM;
        end
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      step_q  <= 2'd0;
      fail_q  <= 1'b0;
      fw_q    <= '0;
      fb_q    <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      step_q  <= step_d;
      fail_q  <= fail_d;
      fw_q    <= fw_d;
      fb_q    <= fb_d;
    end
  end

  assign flush_req = (state_q == ST_FLUSH);
  assign arm_stb   = (state_q == ST_ARM);
  assign arm_allow = arm_stb && op.allow;
  assign req_valid = (state_q == ST_ISSUE);
  assign req_we    = op.we;
  assign req_addr  = agen_addr;
  assign req_wdata = exp_data;
  assign idle_stb  = (state_q == ST_QUIET);
  assign done      = (state_q == ST_DONE);
  assign fail      = fail_q;
  assign fail_word = fw_q;
  assign fail_blk  = fb_q;

  // R1: flush request held until acknowledged
  a_r1_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack && !abort) |=> flush_req);

  // R2: an arm strobe leads straight into a request
  a_r2_arm_then_req: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_stb && !abort) |=> req_valid);

  // R2: strobes and requests are mutually exclusive
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_req, arm_stb, req_valid, idle_stb, done}));

  // R6: stalled request stays stable
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !abort) |=>
      req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata));

  // R7: mismatching read ends the run as failed
  a_r7_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && rsp_valid && (rsp_rdata != exp_data)) |=> done && fail);

  // R9: abort stops the run as failed
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> done && fail);

  // R10: fail is sticky until a start
  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

endmodule

// File: tb/cache_march_seq_tb.sv
module cache_march_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int ND = 4;
  localparam int NB = 8;
  localparam int WW = 2;
  localparam int BW = 3;
  localparam int ELEMS = ND * NB;

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          allow;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n, start, abort, wb_mode;
  logic [DW-1:0] pattern;
  logic          flush_req, flush_ack;
  logic [WW-1:0] elem_word;
  logic [BW-1:0] elem_blk;
  logic [AW-1:0] agen_addr;
  logic          req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          arm_stb, arm_allow, idle_stb, done, fail;
  logic [WW-1:0] fail_word;
  logic [BW-1:0] fail_blk;

  int checks = 0;
  int errors = 0;

  item_t q[$];
  logic [DW-1:0] mem [logic [AW-1:0]];
  int rd_cnt = 0;
  int corrupt_at = -1;
  int idle_cnt = 0;
  int flush_cnt = 0;
  int cyc = 0;
  int flush_wait = 0;
  bit flush_seen = 0;
  bit arm_pend = 0;
  bit arm_val = 0;
  bit rsp_pend = 0;
  logic [DW-1:0] rsp_hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] addr_of(input int w, input int b);
    return 32'h0000_1000 + (AW'(b) << 6) + (AW'(w) << 2);
  endfunction

  assign agen_addr = addr_of(int'(elem_word), int'(elem_blk));

  cache_march_seq #(.AW(AW), .DW(DW), .ND(ND), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .wb_mode(wb_mode),
    .pattern(pattern), .flush_req(flush_req), .flush_ack(flush_ack),
    .elem_word(elem_word), .elem_blk(elem_blk), .agen_addr(agen_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .arm_stb(arm_stb), .arm_allow(arm_allow),
    .idle_stb(idle_stb), .done(done), .fail(fail),
    .fail_word(fail_word), .fail_blk(fail_blk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor and cache model: drives inputs at the falling edge
  initial begin
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_rdata = '0;
    flush_ack = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    req_ready = (cyc % 3) != 1;
    rsp_valid = 1'b0;
    if (rsp_pend) begin
      rsp_valid = 1'b1;
      rsp_rdata = rsp_hold;
      rsp_pend  = 0;
    end
    flush_ack = 1'b0;
    if (flush_req) begin
      if (!flush_seen) begin
        flush_cnt++;
        flush_wait = 0;
      end
      flush_wait++;
      if (flush_wait == 3) flush_ack = 1'b1;
    end
    flush_seen = flush_req;
    if (idle_stb) idle_cnt++;
    if (arm_stb) begin
      arm_pend = 1;
      arm_val  = arm_allow;
    end
    if (req_valid && req_ready) begin
      // R2: exactly one arm before each access
      chk(arm_pend, "R2", "arm before access", 32'(arm_pend), 32'd1);
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected request", req_addr, '0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(req_we == it.we, "R3/R4", "access kind", 32'(req_we), 32'(it.we));
        chk(req_addr == it.addr, "R5", "address order", req_addr, it.addr);
        if (it.we)
          chk(req_wdata == it.data, "R3/R4", "write data", req_wdata, it.data);
        chk(arm_val == it.allow, "R4", "expectation", 32'(arm_val), 32'(it.allow));
      end
      if (req_we) begin
        mem[req_addr] = req_wdata;
      end else begin
        rd_cnt++;
        rsp_hold = mem.exists(req_addr) ? mem[req_addr] : '0;
        if (rd_cnt == corrupt_at) rsp_hold = rsp_hold ^ 32'h0000_0100;
        rsp_pend = 1;
      end
      arm_pend = 0;
    end
  end

  // Driver: pushes the expected accesses of a run into the scoreboard
  task automatic build(input logic wb, input logic [DW-1:0] pat, input int bad_rd,
                       output int fw, output int fb);
    int rd;
    bit stop;
    rd = 0;
    stop = 0;
    fw = -1;
    fb = -1;
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < ND; w++) begin
        for (int b = 0; b < NB; b++) begin
          for (int s = 0; s < (p == 0 ? 2 : 3); s++) begin
            if (!stop) begin
              item_t it;
              it.addr = addr_of(w, b);
              if (p == 0) begin
                // R3: write b allowed, read b not allowed
                it.we = (s == 0);
                it.allow = (s == 0);
                it.data = pat;
              end else begin
                // R4: read allowed, write ~b per policy, read not allowed
                it.we = (s == 1);
                it.allow = (s == 0) || (s == 1 && !wb);
                it.data = (s == 0) ? pat : ~pat;
              end
              q.push_back(it);
              if (!it.we) begin
                rd++;
                if (rd == bad_rd) begin
                  stop = 1;
                  fw = w;
                  fb = b;
                end
              end
            end
          end
        end
      end
    end
  endtask

  task automatic run(input logic wb, input logic [DW-1:0] pat, input int bad_rd,
                     input bit mid_start, input string tag);
    int fw, fb, idle0, flush0, waitc;
    wb_mode = wb;
    pattern = pat;
    build(wb, pat, bad_rd, fw, fb);
    idle0 = idle_cnt;
    flush0 = flush_cnt;
    corrupt_at = (bad_rd > 0) ? rd_cnt + bad_rd : -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R1: flush requested first
    chk(flush_req && !req_valid, "R1", {tag, " flush first"}, 32'(flush_req), 32'd1);
    waitc = 0;
    while (!done && waitc < 20000) begin
      @(negedge clk);
      waitc++;
      if (mid_start && waitc == 60) start = 1'b1;
      if (mid_start && waitc == 61) start = 1'b0;
    end
    chk(done, "R8", {tag, " finished"}, 32'(done), 32'd1);
    chk(flush_cnt - flush0 == 1, "R1", {tag, " one flush"}, 32'(flush_cnt - flush0), 32'd1);
    if (bad_rd > 0) begin
      chk(fail, "R7", {tag, " fail flag"}, 32'(fail), 32'd1);
      chk(int'(fail_word) == fw, "R7", {tag, " fail word"}, 32'(fail_word), 32'(fw));
      chk(int'(fail_blk) == fb, "R7", {tag, " fail block"}, 32'(fail_blk), 32'(fb));
      repeat (10) @(negedge clk);
      chk(!req_valid && done && fail, "R10", {tag, " sticky after fail"},
          32'(fail), 32'd1);
    end else begin
      chk(!fail, "R8", {tag, " no fail"}, 32'(fail), 32'd0);
      chk(idle_cnt - idle0 == 2*ELEMS, "R5", {tag, " idle strobes"},
          32'(idle_cnt - idle0), 32'(2*ELEMS));
      if (mid_start)
        chk(1'b1, "R10", {tag, " start during run ignored"}, '0, '0);
    end
    chk(q.size() == 0, "R5", {tag, " all accesses seen"}, 32'(q.size()), 32'd0);
    q.delete();
    corrupt_at = -1;
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    abort = 1'b0;
    wb_mode = 1'b0;
    pattern = '0;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!done && !fail && !req_valid && !flush_req && !arm_stb && !idle_stb,
        "R11", "reset outputs", {26'd0, done, fail, req_valid, flush_req, arm_stb, idle_stb}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(1'b0, 32'hA5A5_0F0F, 0, 1'b0, "wt");
    run(1'b1, 32'h3C3C_F00F, 0, 1'b1, "wb");
    run(1'b0, 32'h1234_5678, 5, 1'b0, "p1 mismatch");
    run(1'b1, 32'hFFFF_0000, ELEMS + 8, 1'b0, "p2 mismatch");

    // R9: abort mid-run
    begin
      int fw, fb;
      build(1'b1, 32'h0F0F_0F0F, 0, fw, fb);
      wb_mode = 1'b1;
      pattern = 32'h0F0F_0F0F;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      chk(!done, "R9", "busy before abort", 32'(done), 32'd0);
      abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      chk(done && fail, "R9", "abort stops", {30'd0, done, fail}, 32'd3);
      q.delete();
      repeat (8) @(negedge clk);
      chk(done && fail && !req_valid, "R10", "held after abort", 32'(fail), 32'd1);
    end

    // R10: next start clears fail
    run(1'b1, 32'hDEAD_BEEF, 0, 1'b0, "after abort");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule